// File: doc/BRIEF.md
# Cache Retention and Error Control Register

This block is a 32-bit control and status register that sits beside a shared cache. It keeps two sticky error flags. One records uncorrectable (double-bit) ECC errors from the cache RAM. The other records asynchronous errors reported by the external bus interface. Software clears a flag by writing a zero to its bit. Writing a one to a flag bit does nothing, so a read-modify-write cannot set a flag by accident.

The low three bits hold a retention delay code. When the code is non-zero, an internal counter counts timer ticks while the cache reports itself idle. Once the count reaches the threshold the code selects, the block raises a retention request. The request drops in the same cycle that idle falls.

Reads are combinational. The read data shows the register contents in the cycle the read strobe is high, and is zero otherwise.

Top module: `ret_ctl`

## Requirements
- R1: The ECC flag (read bit 30, also output `ecc_flag`) resets to 0, becomes 1 in the cycle after `ram_ecc_err` is high, and stays 1 until it is cleared.
- R2: The bus error flag (read bit 29, also output `bus_flag`) resets to 0, becomes 1 in the cycle after `bus_err` is high, and stays 1 until it is cleared.
- R3: A write with bit 30 (or bit 29) equal to 0 clears that flag from the next cycle on. A write with that bit equal to 1 leaves the flag unchanged.
- R4: When an error pulse and a clearing write reach the same flag in the same cycle, the flag is 1 afterwards.
- R5: Every write loads `wr_data[2:0]` into the delay code, which resets to 000. While the code is 000, `ret_req` stays low.
- R6: Codes 1 to 7 select idle thresholds of 2, 8, 32, 64, 128, 256 and 512 ticks.
- R7: The idle count rises by one on each clock where both `timer_tick` and `cache_idle` are high, stopping at the threshold. It returns to zero on any cycle where `cache_idle` is low or `wr_en` is high.
- R8: `ret_req` is high exactly while the code is non-zero, `cache_idle` is high and the count is at the threshold. It therefore falls in the first cycle that `cache_idle` is low.
- R9: Bits 31 and 28 to 3 always read as 0, and writes to them have no effect.
- R10: `rd_data` shows the current flags and code in the same cycle that `rd_en` is high, and is all zeros while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Register read data, combinational |
| ram_ecc_err | input | 1 | Cache RAM uncorrectable ECC error pulse |
| bus_err | input | 1 | Bus interface asynchronous error pulse |
| cache_idle | input | 1 | Cache idle indication |
| timer_tick | input | 1 | Timer tick strobe |
| ecc_flag | output | 1 | Sticky ECC error flag |
| bus_flag | output | 1 | Sticky bus error flag |
| ret_req | output | 1 | Retention entry request |

## Verification
The hardest situation to reach is the 512-tick threshold. It needs more than 512 cycles of unbroken idle with no register write. Under purely random stimulus, idle drops and writes would restart the count long before that.

The bench therefore runs directed idle runs at codes 7 and 1. It then runs a random phase in which idle and writes change only rarely, so that long runs and mid-count restarts both occur. The same-cycle collision of an error pulse with a clearing write is also forced directly, because random writes seldom coincide with random pulses.

// File: rtl/ret_ctl_pkg.sv
package ret_ctl_pkg;
    localparam int DATA_W  = 32;
    localparam int ECC_BIT = 30;
    localparam int BUS_BIT = 29;
    localparam int DLY_W   = 3;
    localparam int N_FLAGS = 2;
    localparam int CNT_W   = 10;

    typedef logic [DLY_W-1:0] dly_code_t;
    typedef logic [CNT_W-1:0] idle_cnt_t;

    // Threshold per delay code: 2, 8, 32 for codes 1..3, then doubling from 64.
    function automatic idle_cnt_t dly_threshold(dly_code_t code);
        idle_cnt_t thr;
        if (code == '0)
            thr = '0;
        else if (code <= 3)
            thr = idle_cnt_t'(1) << (2 * int'(code) - 1);
        else
            thr = idle_cnt_t'(1) << (int'(code) + 2);
        return thr;
    endfunction

    // Register bit position of each sticky flag.
    function automatic int flag_pos(int idx);
        return (idx == 0) ? ECC_BIT : BUS_BIT;
    endfunction
endpackage

// File: rtl/ret_err_flag.sv
module ret_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i)   flag_d = 1'b0;
        if (event_i) flag_d = 1'b1;   // a new event beats a clearing write
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ret_idle_timer.sv
module ret_idle_timer
    import ret_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_i,
    input  logic      tick_i,
    input  logic      restart_i,
    input  dly_code_t code_i,
    output logic      req_o
);
    idle_cnt_t cnt_d, cnt_q;
    idle_cnt_t thr;
    logic      enabled;

    assign thr     = dly_threshold(code_i);
    assign enabled = (code_i != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (!idle_i || restart_i)
            cnt_d = '0;
        else if (tick_i && enabled && (cnt_q < thr))
            cnt_d = cnt_q + idle_cnt_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign req_o = enabled && idle_i && (cnt_q >= thr);
endmodule

// File: rtl/ret_ctl.sv
module ret_ctl
    import ret_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    input  logic        ram_ecc_err,
    input  logic        bus_err,
    input  logic        cache_idle,
    input  logic        timer_tick,
    output logic        ecc_flag,
    output logic        bus_flag,
    output logic        ret_req
);
    typedef struct packed {
        dly_code_t dly;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic [N_FLAGS-1:0] ev_vec, flag_vec;

    assign ev_vec = {bus_err, ram_ecc_err};

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        ret_err_flag i_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .event_i (ev_vec[g]),
            .clr_i   (wr_en && !wr_data[flag_pos(g)]),
            .flag_o  (flag_vec[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.dly = wr_data[DLY_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ret_idle_timer i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_i    (cache_idle),
        .tick_i    (timer_tick),
        .restart_i (wr_en),
        .code_i    (st_q.dly),
        .req_o     (ret_req)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            rd_data[DLY_W-1:0] = st_q.dly;
            for (int i = 0; i < N_FLAGS; i++)
                rd_data[flag_pos(i)] = flag_vec[i];
        end
    end

    assign ecc_flag = flag_vec[0];
    assign bus_flag = flag_vec[1];
endmodule

// File: rtl/ret_ctl_checker.sv
module ret_ctl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        ram_ecc_err,
    input logic        bus_err,
    input logic        cache_idle,
    input logic        ecc_flag,
    input logic        bus_flag,
    input logic        ret_req
);
    a_r1_ecc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ecc_err |=> ecc_flag);
    a_r2_bus_sets: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> bus_flag);
    a_r3_ecc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_flag && !(wr_en && !wr_data[30])) |=> ecc_flag);
    a_r3_ecc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[30] && !ram_ecc_err) |=> !ecc_flag);
    a_r4_bus_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && wr_en && !wr_data[29]) |=> bus_flag);
    a_r5_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_data[2:0] == 3'b000) |-> !ret_req);
    a_r8_idle_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_idle |-> !ret_req);
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (!rd_data[31] && rd_data[28:3] == '0));
    a_r10_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
    a_r10_flags_visible: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_data[30] == ecc_flag && rd_data[29] == bus_flag));
endmodule

bind ret_ctl ret_ctl_checker i_ret_ctl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .ram_ecc_err (ram_ecc_err),
    .bus_err     (bus_err),
    .cache_idle  (cache_idle),
    .ecc_flag    (ecc_flag),
    .bus_flag    (bus_flag),
    .ret_req     (ret_req)
);

// File: tb/test_ret_ctl.sv
`timescale 1ns/1ps
module test_ret_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        ram_ecc_err = 1'b0;
    logic        bus_err = 1'b0;
    logic        cache_idle = 1'b0;
    logic        timer_tick = 1'b0;
    logic        ecc_flag, bus_flag, ret_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state
    bit       m_ecc, m_bus;
    bit [2:0] m_dly;
    int       m_cnt;

    always #2.5 clk = ~clk;

    ret_ctl i_ret_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .ram_ecc_err(ram_ecc_err),
        .bus_err(bus_err), .cache_idle(cache_idle), .timer_tick(timer_tick),
        .ecc_flag(ecc_flag), .bus_flag(bus_flag), .ret_req(ret_req)
    );

    function automatic int thr_of(bit [2:0] c);
        case (c)
            3'd1: return 2;    3'd2: return 8;    3'd3: return 32;
            3'd4: return 64;   3'd5: return 128;  3'd6: return 256;
            3'd7: return 512;  default: return 0;
        endcase
    endfunction

    function automatic bit exp_req(bit idle);
        return (m_dly != 0) && idle && (m_cnt >= thr_of(m_dly));
    endfunction

    function automatic bit [31:0] exp_rd(bit re);
        bit [31:0] v = '0;
        if (re) begin
            v[30] = m_ecc; v[29] = m_bus; v[2:0] = m_dly;
        end
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive, compare outputs against the model, advance the model.
    task automatic step(bit we, bit [31:0] wd, bit re, bit ecc, bit bus, bit idle, bit tick);
        @(negedge clk);
        wr_en = we; wr_data = wd; rd_en = re;
        ram_ecc_err = ecc; bus_err = bus; cache_idle = idle; timer_tick = tick;
        #1;
        check("R10/R9 rd_data", rd_data, exp_rd(re));
        check("R1/R3/R4 ecc_flag", 32'(ecc_flag), 32'(m_ecc));
        check("R2/R3/R4 bus_flag", 32'(bus_flag), 32'(m_bus));
        check("R5/R6/R7/R8 ret_req", 32'(ret_req), 32'(exp_req(idle)));
        if (!idle || we) m_cnt = 0;
        else if (tick && m_dly != 0 && m_cnt < thr_of(m_dly)) m_cnt++;
        if (we && !wd[30]) m_ecc = 0;
        if (we && !wd[29]) m_bus = 0;
        if (ecc) m_ecc = 1;
        if (bus) m_bus = 1;
        if (we) m_dly = wd[2:0];
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit we, re, ecc, bus, idle, tick;
        bit [31:0] wd;
        void'($urandom(32'd1234));
        m_ecc = 0; m_bus = 0; m_dly = 0; m_cnt = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // Reset state, R1 R2 R5
        step(0, 0, 1, 0, 0, 1, 1);
        check("R5 reset dly", 32'(rd_data[2:0]), 32'd0);
        // Code 0: no request despite idle ticks, R5
        repeat (20) step(0, 0, 1, 0, 0, 1, 1);
        // Reserved bits ignore writes, R9; flags not set by a write of 1, R3
        step(1, 32'hFFFF_FFF9, 0, 0, 0, 1, 0);
        step(0, 0, 1, 0, 0, 1, 0);
        check("R9 reserved read", rd_data & 32'h9FFF_FFF8, 32'd0);
        check("R3 write one no set", 32'(rd_data[30:29]), 32'd0);
        // Code 1: threshold 2, R6 R8
        step(1, 32'd1, 0, 0, 0, 1, 0);
        repeat (4) step(0, 0, 1, 0, 0, 1, 1);
        check("R6 code1 req", 32'(ret_req), 32'd1);
        step(0, 0, 1, 0, 0, 0, 1);   // R8 drop with idle
        // Error set and clear, R1 R2 R3
        step(0, 0, 0, 1, 1, 0, 0);
        step(1, 32'h4000_0001, 1, 0, 0, 0, 0);  // clear bus only
        step(0, 0, 1, 0, 0, 0, 0);
        check("R3 bus cleared ecc kept", 32'(rd_data[30:29]), 32'b10);
        // Collision, R4
        step(1, 32'h0000_0001, 0, 1, 1, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        check("R4 event wins", 32'(rd_data[30:29]), 32'b11);
        step(1, 32'h0000_0007, 0, 0, 0, 0, 0);
        // Code 7: 512 ticks, R6 R7
        repeat (515) step(0, 0, 1, 0, 0, 1, 1);
        check("R6 code7 req", 32'(ret_req), 32'd1);
        step(1, 32'h0000_0007, 0, 0, 0, 1, 1);  // write restarts count, R7
        step(0, 0, 1, 0, 0, 1, 1);
        check("R7 restart on write", 32'(ret_req), 32'd0);

        // Random phase with slow-changing idle and rare writes
        idle = 1;
        for (int n = 0; n < 30000; n++) begin
            if ($urandom_range(0, 299) == 0) idle = ~idle;
            we   = ($urandom_range(0, 249) == 0);
            wd   = $urandom;
            re   = $urandom_range(0, 1);
            ecc  = ($urandom_range(0, 99) == 0);
            bus  = ($urandom_range(0, 99) == 0);
            tick = ($urandom_range(0, 3) != 0);
            step(we, wd, re, ecc, bus, idle, tick);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule